// File: doc/BRIEF.md
# Cascadable Serial Configuration Receiver

This block is the configuration slave of one crosspoint device placed in a two-dimensional grid of identical devices. A single serial data line and its clock enter the device at the top-left corner of the grid. Each device passes the stream to its right-hand neighbour through a row-side output pair and to the device below it through a column-side output pair. Devices carry no fixed address. Instead, every hop lowers one address field of the passing word by one, and a device acts on a word only when both of its address fields have reached zero.

A 30-bit word is sent most significant bit first. It holds a 6-bit start pattern, a 6-bit row field, a 6-bit column field and four 3-bit output codes. Output 1's code is in bits 11:9 and output 4's code is in bits 2:0. A write word addressed to this device fills a load register. A separate load strobe then copies the load register into the live configuration all at once. A read word addressed to this device has the live configuration inserted into its code fields as it passes, so the host can collect it at the far edge of the grid. A hold input detaches the serial clock from all internal state.

Top module: `xpt_cfg_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `cfg_sel` is 0, `err_pulse` is 0, and both forwarded data outputs are 0.
- R2: A write word (start pattern 011111) with row and column fields both 0 and every code in the range 000..100 is stored in the load register when its last bit is sampled. `cfg_sel` does not change until a load strobe occurs.
- R3: When `load_cfg` is high at a rising `sclk` edge with `mode_hold` low, `cfg_sel` takes the load register's value after that edge. Without such an edge, `cfg_sel` keeps its value.
- R4: A write word whose row field or column field is nonzero leaves the load register unchanged.
- R5: In a recognised word, the copy on `col_dout` has its row field (bits 23:18) reduced by one modulo 64. The copy on `row_dout` has its column field (bits 17:12) reduced by one modulo 64. All other bits are passed unchanged.
- R6: A bit sampled from `ser_in` at rising edge n appears on `row_dout` and `col_dout` after rising edge n+6, which is seven edges counting the sampling edge.
- R7: While idle, the receiver recognises a start pattern at any bit offset, whatever bits come before it.
- R8: A word whose start pattern is neither 011111 nor 011110 stores nothing and is forwarded bit for bit with no address change.
- R9: For a read word (start pattern 011110) with both address fields 0, the code fields of both forwarded copies carry the live `cfg_sel`, and the load register is not altered. A write word that follows directly, with no gap, is accepted.
- R10: An addressed write word that contains a code from 101 to 111 leaves the load register unchanged. In that case `err_pulse` is high for exactly one `sclk` cycle, starting at the edge that samples the word's last bit.
- R11: While `mode_hold` is high, `ser_in` and `load_cfg` have no effect on any state, and `row_clk` and `col_clk` stay low. While `mode_hold` is low, `row_clk` and `col_clk` follow `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial control clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_in | input | 1 | Serial control data, sampled on rising `sclk` |
| load_cfg | input | 1 | Copies the load register into the live configuration |
| mode_hold | input | 1 | High detaches `sclk` from internal state |
| row_dout | output | 1 | Forwarded data to the row neighbour (column field reduced) |
| row_clk | output | 1 | Forwarded clock to the row neighbour, low while held |
| col_dout | output | 1 | Forwarded data to the column neighbour (row field reduced) |
| col_clk | output | 1 | Forwarded clock to the column neighbour, low while held |
| cfg_sel | output | 12 | Live configuration, output 1's code in bits 11:9 |
| err_pulse | output | 1 | One-cycle flag for an addressed write carrying an invalid code |

## Verification
The embedded properties assume that `ser_in`, `load_cfg` and `mode_hold` are stable around each rising `sclk` edge. They also assume that `mode_hold` moves only while `sclk` is low, so the forwarded clocks never see a runt pulse. The bench changes every input on the falling edge, and the stimulus keeps `mode_hold` steady across rising edges. The stimulus also avoids the case where the tail of a word, together with the following idle bits, could itself form a start pattern: valid output codes never end in four ones, and the idle filler is always zero.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;

  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_BODY = 1'b1
  } rx_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/xpt_rst_sync.sv
module xpt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/xpt_fwd_pipe.sv
// Seven-stage forward path. On a load strobe the address field that has
// just fully arrived is rewritten, reduced by one, in place.
module xpt_fwd_pipe #(
  parameter int ADDR_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  input  logic ld,
  output logic dout
);

  localparam int DEPTH = ADDR_W + 1;

  logic [DEPTH-1:0]  pipe_q, pipe_n;
  logic [ADDR_W-1:0] field_w;

  assign field_w = {pipe_q[ADDR_W-2:0], din};

  always_comb begin
    if (ld) pipe_n = {pipe_q[ADDR_W-1], field_w - 1'b1};
    else    pipe_n = {pipe_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pipe_q <= '0;
    else if (en) pipe_q <= pipe_n;
  end

  assign dout = pipe_q[DEPTH-1];

endmodule

// File: rtl/xpt_cfg_frame.sv
// Start-pattern hunt, field position tracking, address match, load register
// capture and read-back insertion.
module xpt_cfg_frame
  import xpt_cfg_pkg::*;
#(
  parameter int          SOF_W  = 6,
  parameter int          ADDR_W = 6,
  parameter int          CODE_W = 3,
  parameter int          N_OUT  = 4,
  parameter int          N_IN   = 4,
  parameter logic [5:0]  WR_SOF = 6'b011111,
  parameter logic [5:0]  RD_SOF = 6'b011110,
  parameter int          CFG_W  = CODE_W * N_OUT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ser_in,
  input  logic [CFG_W-1:0] cfg_cur,
  output logic             row_end,
  output logic             col_end,
  output logic             ins_en,
  output logic             ins_bit,
  output logic [CFG_W-1:0] load_val,
  output logic             err
);

  localparam int BODY_LEN = 2 * ADDR_W + CFG_W;
  localparam int POS_W    = $clog2(BODY_LEN);
  localparam int WIN_W    = max3(SOF_W, ADDR_W, CFG_W);

  rx_state_e        st_q, st_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic             rd_q, rd_n;
  logic             rz_q, rz_n;
  logic             cz_q, cz_n;
  logic [CFG_W-1:0] sh_q, sh_n;
  logic [CFG_W-1:0] load_q, load_n;
  logic             err_q, err_n;
  logic [WIN_W-2:0] win_q;
  logic [WIN_W-1:0] win_n;

  logic             in_body, last_w, code_w, field_zero, sof_hit, sof_rd;
  logic             addressed, capture, codes_ok;
  logic [CFG_W-1:0] cap_w;

  assign win_n      = {win_q, ser_in};
  assign sof_rd     = (win_n[SOF_W-1:0] == RD_SOF[SOF_W-1:0]);
  assign sof_hit    = (st_q == RX_HUNT) &&
                      ((win_n[SOF_W-1:0] == WR_SOF[SOF_W-1:0]) || sof_rd);
  assign in_body    = (st_q == RX_BODY);
  assign row_end    = in_body && (pos_q == POS_W'(ADDR_W - 1));
  assign col_end    = in_body && (pos_q == POS_W'(2 * ADDR_W - 1));
  assign last_w     = in_body && (pos_q == POS_W'(BODY_LEN - 1));
  assign code_w     = in_body && (pos_q >= POS_W'(2 * ADDR_W));
  assign field_zero = (win_n[ADDR_W-1:0] == '0);
  assign cap_w      = win_n[CFG_W-1:0];
  assign addressed  = rz_q && cz_q;
  assign capture    = en && last_w && !rd_q && addressed;

  always_comb begin
    codes_ok = 1'b1;
    for (int k = 0; k < N_OUT; k++) begin
      if (cap_w[k*CODE_W +: CODE_W] > CODE_W'(N_IN)) codes_ok = 1'b0;
    end
  end

  always_comb begin
    st_n   = st_q;
    pos_n  = pos_q;
    rd_n   = rd_q;
    rz_n   = rz_q;
    cz_n   = cz_q;
    sh_n   = sh_q;
    load_n = load_q;
    err_n  = 1'b0;
    case (st_q)
      RX_HUNT: begin
        if (sof_hit) begin
          st_n  = RX_BODY;
          pos_n = '0;
          rd_n  = sof_rd;
        end
      end
      default: begin
        pos_n = pos_q + 1'b1;
        if (row_end) rz_n = field_zero;
        if (col_end) begin
          cz_n = field_zero;
          sh_n = cfg_cur;
        end
        if (code_w) sh_n = {sh_q[CFG_W-2:0], 1'b0};
        if (last_w) begin
          st_n  = RX_HUNT;
          pos_n = '0;
          if (!rd_q && addressed) begin
            if (codes_ok) load_n = cap_w;
            else          err_n  = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_HUNT;
      pos_q  <= '0;
      rd_q   <= 1'b0;
      rz_q   <= 1'b0;
      cz_q   <= 1'b0;
      sh_q   <= '0;
      load_q <= '0;
      err_q  <= 1'b0;
      win_q  <= '0;
    end else if (en) begin
      st_q   <= st_n;
      pos_q  <= pos_n;
      rd_q   <= rd_n;
      rz_q   <= rz_n;
      cz_q   <= cz_n;
      sh_q   <= sh_n;
      load_q <= load_n;
      err_q  <= err_n;
      win_q  <= win_n[WIN_W-2:0];
    end
  end

  assign ins_en   = code_w && rd_q && addressed;
  assign ins_bit  = sh_q[CFG_W-1];
  assign load_val = load_q;
  assign err      = err_q;

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(en && last_w && !rd_q && addressed));

  // R2
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(load_q) |-> $past(capture && codes_ok));

endmodule

// File: rtl/xpt_cfg_rx.sv
module xpt_cfg_rx
  import xpt_cfg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CODE_W = 3,
  parameter int N_OUT  = 4,
  parameter int N_IN   = 4,
  parameter int CFG_W  = CODE_W * N_OUT
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             load_cfg,
  input  logic             mode_hold,
  output logic             row_dout,
  output logic             row_clk,
  output logic             col_dout,
  output logic             col_clk,
  output logic [CFG_W-1:0] cfg_sel,
  output logic             err_pulse
);

  localparam int N_PORT = 2;

  logic             rst_q, en;
  logic             row_end, col_end, ins_en, ins_bit, fwd_bit;
  logic [CFG_W-1:0] load_val, cfg_q, cfg_n;
  logic [N_PORT-1:0] ld_vec, dout_vec;

  assign en      = !mode_hold;
  assign fwd_bit = ins_en ? ins_bit : ser_in;

  xpt_rst_sync u_rst (
    .clk       (sclk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  xpt_cfg_frame #(
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W),
    .N_OUT  (N_OUT),
    .N_IN   (N_IN),
    .CFG_W  (CFG_W)
  ) u_frame (
    .clk      (sclk),
    .rst_n    (rst_q),
    .en       (en),
    .ser_in   (ser_in),
    .cfg_cur  (cfg_q),
    .row_end  (row_end),
    .col_end  (col_end),
    .ins_en   (ins_en),
    .ins_bit  (ins_bit),
    .load_val (load_val),
    .err      (err_pulse)
  );

  // port 0 feeds the row neighbour and lowers the column field,
  // port 1 feeds the column neighbour and lowers the row field
  assign ld_vec[0] = col_end;
  assign ld_vec[1] = row_end;

  for (genvar g = 0; g < N_PORT; g++) begin : g_port
    xpt_fwd_pipe #(.ADDR_W(ADDR_W)) u_pipe (
      .clk  (sclk),
      .rst_n(rst_q),
      .en   (en),
      .din  (fwd_bit),
      .ld   (ld_vec[g]),
      .dout (dout_vec[g])
    );
  end

  assign row_dout = dout_vec[0];
  assign col_dout = dout_vec[1];
  assign row_clk  = sclk & en;
  assign col_clk  = sclk & en;

  always_comb begin
    cfg_n = cfg_q;
    if (load_cfg) cfg_n = load_val;
  end

  always_ff @(posedge sclk or negedge rst_q) begin
    if (!rst_q)  cfg_q <= '0;
    else if (en) cfg_q <= cfg_n;
  end

  assign cfg_sel = cfg_q;

  // R3
  cfg_hold_chk: assert property (@(posedge sclk) disable iff (!rst_q)
    !(load_cfg && !mode_hold) |=> $stable(cfg_sel));

  // R10
  err_once_chk: assert property (@(posedge sclk) disable iff (!rst_q)
    (err_pulse && !mode_hold) |=> !err_pulse);

  // R11
  hold_frz_chk: assert property (@(posedge sclk) disable iff (!rst_q)
    mode_hold |=> ($stable(err_pulse) && $stable(row_dout) && $stable(col_dout)));

endmodule

// File: tb/tb_xpt_cfg_rx.sv
module tb_xpt_cfg_rx;

  localparam logic [5:0] WR = 6'b011111;
  localparam logic [5:0] RD = 6'b011110;
  localparam int NV = 9;

  // {word[29:0], cfg after load[11:0], error flag}
  localparam logic [42:0] VECS [0:NV-1] = '{
    {WR, 6'd0,  6'd0,  12'h29C, 12'h29C, 1'b0},
    {WR, 6'd1,  6'd0,  12'h924, 12'h29C, 1'b0},
    {WR, 6'd0,  6'd2,  12'h000, 12'h29C, 1'b0},
    {RD, 6'd0,  6'd0,  12'h000, 12'h29C, 1'b0},
    {WR, 6'd0,  6'd0,  12'h8D1, 12'h8D1, 1'b0},
    {WR, 6'd0,  6'd0,  12'h349, 12'h8D1, 1'b1},
    {6'b011100, 6'd0, 6'd0, 12'h249, 12'h8D1, 1'b0},
    {WR, 6'd63, 6'd63, 12'h249, 12'h8D1, 1'b0},
    {WR, 6'd0,  6'd0,  12'h000, 12'h000, 1'b0}
  };

  logic        sclk = 1'b0;
  logic        rst_n, ser_in, load_cfg, mode_hold;
  logic        row_dout, row_clk, col_dout, col_clk, err_pulse;
  logic [11:0] cfg_sel;

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  logic rec_row [0:4095];
  logic rec_col [0:4095];

  always #4 sclk = ~sclk;

  xpt_cfg_rx dut (
    .sclk(sclk), .rst_n(rst_n), .ser_in(ser_in), .load_cfg(load_cfg),
    .mode_hold(mode_hold), .row_dout(row_dout), .row_clk(row_clk),
    .col_dout(col_dout), .col_clk(col_clk), .cfg_sel(cfg_sel),
    .err_pulse(err_pulse)
  );

  always @(posedge sclk) edge_n <= edge_n + 1;

  always @(negedge sclk) begin
    if (edge_n < 4096) begin
      rec_row[edge_n] = row_dout;
      rec_col[edge_n] = col_dout;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [29:0] w, output int first);
    @(negedge sclk);
    first    = edge_n + 1;
    ser_in   = w[29];
    load_cfg = 1'b0;
    for (int i = 28; i >= 0; i--) begin
      @(negedge sclk);
      ser_in = w[i];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sclk);
      ser_in   = 1'b0;
      load_cfg = 1'b0;
    end
  endtask

  // one load strobe right after a word, checks the error flag around it
  task automatic finish_word(input logic exp_err, input logic [11:0] exp_cfg, input string tag);
    @(negedge sclk);
    chk({tag, " R10 err flag"}, {31'd0, err_pulse}, {31'd0, exp_err});
    ser_in   = 1'b0;
    load_cfg = 1'b1;
    @(negedge sclk);
    load_cfg = 1'b0;
    chk({tag, " R10 err single cycle"}, {31'd0, err_pulse}, 32'd0);
    chk({tag, " R2 R3 R4 cfg after load"}, {20'd0, cfg_sel}, {20'd0, exp_cfg});
  endtask

  function automatic logic [29:0] got_fwd(input bit colport, input int first);
    logic [29:0] v;
    for (int i = 0; i < 30; i++) v[29-i] = colport ? rec_col[first+i+6] : rec_row[first+i+6];
    return v;
  endfunction

  function automatic logic [29:0] exp_fwd(input logic [29:0] w, input logic [11:0] c, input bit colport);
    logic [29:0] r;
    r = w;
    if (w[29:24] == WR || w[29:24] == RD) begin
      if (colport) r[23:18] = w[23:18] - 6'd1;
      else         r[17:12] = w[17:12] - 6'd1;
      if (w[29:24] == RD && w[23:18] == 6'd0 && w[17:12] == 6'd0) r[11:0] = c;
    end
    return r;
  endfunction

  task automatic chk_fwd(input logic [29:0] w, input logic [11:0] c, input int first, input string tag);
    chk({tag, " R5 R8 R9 row port word"}, {2'd0, got_fwd(1'b0, first)}, {2'd0, exp_fwd(w, c, 1'b0)});
    chk({tag, " R5 R8 R9 col port word"}, {2'd0, got_fwd(1'b1, first)}, {2'd0, exp_fwd(w, c, 1'b1)});
  endtask

  initial begin
    logic [11:0] model_cfg;
    logic [29:0] w;
    int f0, f1;
    rst_n = 1'b0; ser_in = 1'b0; load_cfg = 1'b0; mode_hold = 1'b0;
    repeat (3) @(negedge sclk);
    // R1 during reset
    chk("R1 cfg in reset", {20'd0, cfg_sel}, 32'd0);
    chk("R1 err in reset", {31'd0, err_pulse}, 32'd0);
    rst_n = 1'b1;
    idle(10);
    chk("R1 cfg after reset", {20'd0, cfg_sel}, 32'd0);
    chk("R1 fwd outputs after reset", {30'd0, row_dout, col_dout}, 32'd0);

    model_cfg = 12'h000;
    for (int v = 0; v < NV; v++) begin
      w = VECS[v][42:13];
      idle(v % 4);                               // R7 varying offsets
      put_word(w, f0);
      finish_word(VECS[v][0], VECS[v][12:1], $sformatf("vec%0d", v));
      idle(8);
      chk_fwd(w, model_cfg, f0, $sformatf("vec%0d", v));
      if (v == 0) begin
        // R6 second bit (a 1) arrives after edge n+6, not earlier
        chk("R6 latency edge n+6", {31'd0, rec_row[f0+1+6]}, 32'd1);
        chk("R6 not before edge n+6", {31'd0, rec_row[f0+1+5]}, 32'd0);
        chk("R6 col port latency", {31'd0, rec_col[f0+1+6]}, 32'd1);
      end
      model_cfg = VECS[v][12:1];
    end

    // R9 read followed immediately by a write, no gap
    put_word({RD, 6'd0, 6'd0, 12'h000}, f0);
    put_word({WR, 6'd0, 6'd0, 12'h249}, f1);
    finish_word(1'b0, 12'h249, "R9 back-to-back");
    idle(8);
    chk_fwd({RD, 6'd0, 6'd0, 12'h000}, 12'h000, f0, "R9 read");
    chk_fwd({WR, 6'd0, 6'd0, 12'h249}, 12'h000, f1, "R9 following write");

    // R7 start found after arbitrary leading bits 1101
    @(negedge sclk); ser_in = 1'b1;
    @(negedge sclk); ser_in = 1'b1;
    @(negedge sclk); ser_in = 1'b0;
    @(negedge sclk); ser_in = 1'b1;
    put_word({WR, 6'd0, 6'd0, 12'h492}, f0);
    finish_word(1'b0, 12'h492, "R7 unaligned");
    idle(8);

    // R11 hold: clocks low, serial data and load ignored
    @(negedge sclk); mode_hold = 1'b1;
    @(posedge sclk); #1;
    chk("R11 row_clk low while held", {31'd0, row_clk}, 32'd0);
    chk("R11 col_clk low while held", {31'd0, col_clk}, 32'd0);
    put_word({WR, 6'd0, 6'd0, 12'h6DB}, f0);
    @(negedge sclk); load_cfg = 1'b1;
    @(negedge sclk); load_cfg = 1'b1;
    @(negedge sclk); load_cfg = 1'b0;
    chk("R11 cfg unchanged while held", {20'd0, cfg_sel}, 32'h492);
    @(negedge sclk); mode_hold = 1'b0;
    @(posedge sclk); #1;
    chk("R11 row_clk follows sclk", {31'd0, row_clk}, 32'd1);
    chk("R11 col_clk follows sclk", {31'd0, col_clk}, 32'd1);
    @(negedge sclk); load_cfg = 1'b1;
    @(negedge sclk); load_cfg = 1'b0;
    chk("R11 load register untouched by held word", {20'd0, cfg_sel}, 32'h492);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge sclk);
    checks++;
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule